// File: doc/BRIEF.md
# Tiled Thermometer Slice-Enable Decoder

This block drives the digital control lines of a segmented output driver that is built from 63 identical slices. It takes two signed-magnitude symbols per pair period. Each symbol is a 6-bit magnitude plus a sign bit. The block emits them one after the other, even symbol first, as a 63-wire enable vector and one shared complementary sign pair. The number of enabled slices always equals the magnitude.

Decoding happens in two stages. The first stage turns each symbol's magnitude into two short thermometer codes and holds them in one register set per phase. The upper bits become a coarse code across seven groups of eight slices. The lower bits become a fine code across a separate seven-slice group. A small phase state machine then picks the even or odd register set. The second stage expands the chosen codes to 63 wires and registers them together with the sign. The analog slices lie outside this block.

The phase state machine has three states:
- PH_IDLE: the output is dark.
- PH_EVEN: the even symbol is routed to the output stage.
- PH_ODD: the odd symbol is routed to the output stage.

It has five transitions:
- IDLE_HOLD: PH_IDLE to PH_IDLE while `run` is low.
- IDLE_START: PH_IDLE to PH_EVEN when `run` is high.
- EVEN_TO_ODD: PH_EVEN to PH_ODD, which always happens.
- ODD_NEXT: PH_ODD to PH_EVEN when `run` is high.
- ODD_STOP: PH_ODD to PH_IDLE when `run` is low.

Top module: `segdec_top`

## Requirements
- R1: After reset, and on the edge after any cycle spent in PH_IDLE, `slice_en` is all zero, `sign_p` is 0 and `sign_n` is 1.
- R2: While streaming, the number of ones in `slice_en` equals the magnitude of the symbol being shown (0 to 63).
- R3: Bit layout of `slice_en`: group g (g = 0..6) occupies bits [8g+7:8g], and all 8 of its bits are on exactly when g < code[5:3]. Bit 56+j (j = 0..6) is on exactly when j < code[2:0].
- R4: A magnitude of zero enables no slice, whichever sign accompanies it.
- R5: `sign_p` equals the shown symbol's sign bit (1 = positive drive), and `sign_n` is its complement. Both change on the same clock edge as the enables of that symbol.
- R6: A pair is captured on an edge where the state machine is in PH_IDLE or PH_ODD. The even symbol appears on the next edge and the odd symbol on the edge after that. The pairs form a gapless alternating stream while `run` stays high.
- R7: Lowering `run` never cuts a pair short. The odd symbol is still shown, and the output goes dark on the following edge.
- R8: Pair inputs that change during a PH_EVEN cycle do not affect the odd symbol of the pair already captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Stream enable; sampled in PH_IDLE and PH_ODD |
| even_code | input | 6 | Magnitude of the first symbol of the pair |
| even_sign | input | 1 | Sign of the first symbol (1 = positive) |
| odd_code | input | 6 | Magnitude of the second symbol of the pair |
| odd_sign | input | 1 | Sign of the second symbol (1 = positive) |
| slice_en | output | 63 | Registered per-slice enables |
| sign_p | output | 1 | Registered shared sign |
| sign_n | output | 1 | Registered complement of the shared sign |

## Verification
A pair presented before a capturing edge shows its even symbol one edge later and its odd symbol two edges later. The dark output that follows a stop request comes one edge after the last odd symbol. The bench drives inputs and samples outputs on falling edges, and it walks these edges one by one.

The bench presents the next pair right after the capture edge, which is inside the PH_EVEN cycle. Any early capture therefore corrupts the odd symbol that is checked. Sign and enables are compared in the same sample, so any skew between them shows up as a failure.

// File: rtl/segdec_pkg.sv
package segdec_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_EVEN = 2'd1,
        PH_ODD  = 2'd2
    } phase_e;

    localparam int SEGDEC_MAG_W_DEFAULT = 6;

endpackage

// File: rtl/segdec_phase_fsm.sv
module segdec_phase_fsm
    import segdec_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run,
    output phase_e phase_q,
    output logic   load_pair
);

    phase_e phase_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_nxt;
        end
    end

    // Transitions: IDLE_HOLD, IDLE_START, EVEN_TO_ODD, ODD_NEXT, ODD_STOP
    always_comb begin
        phase_nxt = PH_IDLE;
        unique case (phase_q)
            PH_IDLE: phase_nxt = run ? PH_EVEN : PH_IDLE;
            PH_EVEN: phase_nxt = PH_ODD;
            PH_ODD:  phase_nxt = run ? PH_EVEN : PH_IDLE;
            default: phase_nxt = PH_IDLE;
        endcase
    end

    // Outputs: a new pair is taken on every edge that does not end an even cycle
    always_comb begin
        load_pair = 1'b0;
        unique case (phase_q)
            PH_IDLE: load_pair = 1'b1;
            PH_EVEN: load_pair = 1'b0;
            PH_ODD:  load_pair = 1'b1;
            default: load_pair = 1'b1;
        endcase
    end

endmodule

// File: rtl/segdec_stage1.sv
module segdec_stage1 #(
    parameter int MAG_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [MAG_W-1:0]      code,
    input  logic                  sign,
    output logic [(2**(MAG_W-MAG_W/2))-2:0] coarse_q,
    output logic [(2**(MAG_W/2))-2:0]       fine_q,
    output logic                  sign_q
);

    localparam int FINE_W   = MAG_W / 2;
    localparam int COARSE_W = MAG_W - FINE_W;
    localparam int N_GROUPS = (2 ** COARSE_W) - 1;
    localparam int FINE_SL  = (2 ** FINE_W) - 1;

    logic [COARSE_W-1:0] code_hi;
    logic [FINE_W-1:0]   code_lo;
    logic [N_GROUPS-1:0] coarse_th;
    logic [FINE_SL-1:0]  fine_th;

    assign code_hi = code[MAG_W-1:FINE_W];
    assign code_lo = code[FINE_W-1:0];

    // Coarse thermometer: group g lit when upper field exceeds g
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_coarse
        assign coarse_th[g] = (code_hi > COARSE_W'(g));
    end

    // Fine thermometer: slice j lit when lower field exceeds j
    for (genvar j = 0; j < FINE_SL; j++) begin : g_fine
        assign fine_th[j] = (code_lo > FINE_W'(j));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_q <= '0;
            fine_q   <= '0;
            sign_q   <= 1'b0;
        end else if (load) begin
            coarse_q <= coarse_th;
            fine_q   <= fine_th;
            sign_q   <= sign;
        end
    end

endmodule

// File: rtl/segdec_stage2.sv
module segdec_stage2
    import segdec_pkg::*;
#(
    parameter int MAG_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  phase_e phase,
    input  logic [1:0][(2**(MAG_W-MAG_W/2))-2:0] coarse_in,
    input  logic [1:0][(2**(MAG_W/2))-2:0]       fine_in,
    input  logic [1:0]                           sign_in,
    output logic [(2**MAG_W)-2:0] slice_en,
    output logic                  sign_p,
    output logic                  sign_n
);

    localparam int FINE_W   = MAG_W / 2;
    localparam int COARSE_W = MAG_W - FINE_W;
    localparam int N_GROUPS = (2 ** COARSE_W) - 1;
    localparam int GROUP_SL = 2 ** FINE_W;
    localparam int FINE_SL  = (2 ** FINE_W) - 1;
    localparam int N_SLICES = (2 ** MAG_W) - 1;
    localparam int FINE_LSB = N_GROUPS * GROUP_SL;

    logic [N_GROUPS-1:0] sel_coarse;
    logic [FINE_SL-1:0]  sel_fine;
    logic                sel_sign;
    logic                sel_live;
    logic [N_SLICES-1:0] en_nxt;

    // Phase multiplexer between the two decode stages
    always_comb begin
        sel_coarse = '0;
        sel_fine   = '0;
        sel_sign   = 1'b0;
        sel_live   = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                sel_live = 1'b0;
            end
            PH_EVEN: begin
                sel_coarse = coarse_in[0];
                sel_fine   = fine_in[0];
                sel_sign   = sign_in[0];
                sel_live   = 1'b1;
            end
            PH_ODD: begin
                sel_coarse = coarse_in[1];
                sel_fine   = fine_in[1];
                sel_sign   = sign_in[1];
                sel_live   = 1'b1;
            end
            default: begin
                sel_live = 1'b0;
            end
        endcase
    end

    // Expansion of each coarse bit to a full group of slices
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_expand
        assign en_nxt[g*GROUP_SL +: GROUP_SL] = {GROUP_SL{sel_coarse[g]}};
    end
    assign en_nxt[FINE_LSB +: FINE_SL] = sel_fine;

    // Output register: enables and sign leave on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slice_en <= '0;
            sign_p   <= 1'b0;
            sign_n   <= 1'b1;
        end else if (sel_live) begin
            slice_en <= en_nxt;
            sign_p   <= sel_sign;
            sign_n   <= ~sel_sign;
        end else begin
            slice_en <= '0;
            sign_p   <= 1'b0;
            sign_n   <= 1'b1;
        end
    end

endmodule

// File: rtl/segdec_top.sv
module segdec_top
    import segdec_pkg::*;
#(
    parameter int MAG_W = SEGDEC_MAG_W_DEFAULT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic [MAG_W-1:0]      even_code,
    input  logic                  even_sign,
    input  logic [MAG_W-1:0]      odd_code,
    input  logic                  odd_sign,
    output logic [(2**MAG_W)-2:0] slice_en,
    output logic                  sign_p,
    output logic                  sign_n
);

    localparam int FINE_W   = MAG_W / 2;
    localparam int COARSE_W = MAG_W - FINE_W;
    localparam int N_GROUPS = (2 ** COARSE_W) - 1;
    localparam int FINE_SL  = (2 ** FINE_W) - 1;

    phase_e phase_q;
    logic   load_pair;

    logic [1:0][MAG_W-1:0]    ph_code;
    logic [1:0]               ph_sign;
    logic [1:0][N_GROUPS-1:0] s1_coarse;
    logic [1:0][FINE_SL-1:0]  s1_fine;
    logic [1:0]               s1_sign;

    assign ph_code[0] = even_code;
    assign ph_code[1] = odd_code;
    assign ph_sign[0] = even_sign;
    assign ph_sign[1] = odd_sign;

    segdec_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .phase_q   (phase_q),
        .load_pair (load_pair)
    );

    // One first-stage register set per phase
    for (genvar p = 0; p < 2; p++) begin : g_phase
        segdec_stage1 #(.MAG_W(MAG_W)) u_s1 (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_pair),
            .code     (ph_code[p]),
            .sign     (ph_sign[p]),
            .coarse_q (s1_coarse[p]),
            .fine_q   (s1_fine[p]),
            .sign_q   (s1_sign[p])
        );
    end

    segdec_stage2 #(.MAG_W(MAG_W)) u_s2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase_q),
        .coarse_in (s1_coarse),
        .fine_in   (s1_fine),
        .sign_in   (s1_sign),
        .slice_en  (slice_en),
        .sign_p    (sign_p),
        .sign_n    (sign_n)
    );

endmodule

// File: rtl/segdec_checker.sv
module segdec_checker
    import segdec_pkg::*;
#(
    parameter int MAG_W = 6
) (
    input logic clk,
    input logic rst_n,
    input phase_e phase,
    input logic [(2**MAG_W)-2:0] slice_en,
    input logic sign_p,
    input logic sign_n,
    input logic [(2**(MAG_W-MAG_W/2))-2:0] even_coarse,
    input logic [(2**(MAG_W/2))-2:0]       even_fine,
    input logic [(2**(MAG_W-MAG_W/2))-2:0] odd_coarse,
    input logic [(2**(MAG_W/2))-2:0]       odd_fine
);

    localparam int FINE_W   = MAG_W / 2;
    localparam int COARSE_W = MAG_W - FINE_W;
    localparam int N_GROUPS = (2 ** COARSE_W) - 1;
    localparam int GROUP_SL = 2 ** FINE_W;
    localparam int FINE_SL  = (2 ** FINE_W) - 1;
    localparam int FINE_LSB = N_GROUPS * GROUP_SL;

    int   cnt_even;
    int   cnt_odd;
    logic shape_ok;

    always_comb begin
        cnt_even = $countones(even_coarse) * GROUP_SL + $countones(even_fine);
        cnt_odd  = $countones(odd_coarse) * GROUP_SL + $countones(odd_fine);
    end

    // Groups uniform and filled from the bottom; fine part filled from the bottom
    always_comb begin
        shape_ok = 1'b1;
        for (int g = 0; g < N_GROUPS; g++) begin
            for (int k = 1; k < GROUP_SL; k++) begin
                if (slice_en[g*GROUP_SL + k] != slice_en[g*GROUP_SL]) shape_ok = 1'b0;
            end
            if (g > 0 && slice_en[g*GROUP_SL] && !slice_en[(g-1)*GROUP_SL]) shape_ok = 1'b0;
        end
        for (int j = 1; j < FINE_SL; j++) begin
            if (slice_en[FINE_LSB + j] && !slice_en[FINE_LSB + j - 1]) shape_ok = 1'b0;
        end
    end

    AST_SIGN_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        sign_p != sign_n);                                                  // R5

    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_IDLE |=> (slice_en == '0 && !sign_p));                  // R1

    AST_EVEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_EVEN |=> $countones(slice_en) == $past(cnt_even));      // R2

    AST_ODD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_ODD |=> $countones(slice_en) == $past(cnt_odd));        // R6

    AST_TILE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        shape_ok);                                                          // R3

    AST_PAIR_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_EVEN |=> phase == PH_ODD);                              // R7

    AST_ODD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_EVEN |=> ($stable(odd_coarse) && $stable(odd_fine)));   // R8

endmodule

bind segdec_top segdec_checker #(.MAG_W(MAG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase       (phase_q),
    .slice_en    (slice_en),
    .sign_p      (sign_p),
    .sign_n      (sign_n),
    .even_coarse (s1_coarse[0]),
    .even_fine   (s1_fine[0]),
    .odd_coarse  (s1_coarse[1]),
    .odd_fine    (s1_fine[1])
);

// File: tb/segdec_top_test.sv
module segdec_top_test;

    localparam int MAG_W    = 6;
    localparam int N_SLICES = 63;
    localparam int GROUP_SL = 8;
    localparam int N_GROUPS = 7;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                run = 1'b0;
    logic [MAG_W-1:0]    even_code = '0;
    logic                even_sign = 1'b0;
    logic [MAG_W-1:0]    odd_code = '0;
    logic                odd_sign = 1'b0;
    logic [N_SLICES-1:0] slice_en;
    logic                sign_p;
    logic                sign_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int s_ec [0:63];
    bit s_es [0:63];
    int s_oc [0:63];
    bit s_os [0:63];

    always #10 clk = ~clk;   // 50 MHz

    segdec_top #(.MAG_W(MAG_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .even_code (even_code),
        .even_sign (even_sign),
        .odd_code  (odd_code),
        .odd_sign  (odd_sign),
        .slice_en  (slice_en),
        .sign_p    (sign_p),
        .sign_n    (sign_n)
    );

    // Expected pattern from the layout rule of R3
    function automatic logic [N_SLICES-1:0] exp_vec(int code);
        logic [N_SLICES-1:0] v;
        v = '0;
        for (int k = 0; k < N_SLICES; k++) begin
            if (k < N_GROUPS * GROUP_SL) v[k] = ((k / GROUP_SL) < (code / GROUP_SL));
            else                         v[k] = ((k - N_GROUPS * GROUP_SL) < (code % GROUP_SL));
        end
        return v;
    endfunction

    task automatic check_sym(string req, int code, bit sgn);
        logic [N_SLICES-1:0] ev;
        ev = exp_vec(code);
        checks++;
        if ($countones(slice_en) != code) begin
            fails++;
            $display("FAIL R2 %s: enabled count %0d expected %0d", req, $countones(slice_en), code);
        end
        checks++;
        if (slice_en !== ev || sign_p !== sgn || sign_n !== ~sgn) begin
            fails++;
            $display("FAIL %s: en=%h sp=%b sn=%b expected en=%h sp=%b sn=%b",
                     req, slice_en, sign_p, sign_n, ev, sgn, ~sgn);
        end
    endtask

    task automatic check_dark(string req);
        checks++;
        if (slice_en !== '0 || sign_p !== 1'b0 || sign_n !== 1'b1) begin
            fails++;
            $display("FAIL %s: en=%h sp=%b sn=%b expected en=0 sp=0 sn=1",
                     req, slice_en, sign_p, sign_n);
        end
    endtask

    task automatic drive_pair(int i);
        even_code = MAG_W'(s_ec[i]);
        even_sign = s_es[i];
        odd_code  = MAG_W'(s_oc[i]);
        odd_sign  = s_os[i];
    endtask

    // Streams n stored pairs, checking each symbol on its due edge (R6)
    task automatic run_stream(int n, string req);
        @(negedge clk);
        run = 1'b1;
        drive_pair(0);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);                 // capture of pair i
            @(negedge clk);
            if (i > 0) check_sym({req, " R6 R8 odd"}, s_oc[i-1], s_os[i-1]);
            if (i + 1 < n) begin
                drive_pair(i + 1);          // changes during PH_EVEN (R8)
            end else begin
                run       = 1'b0;           // stop requested mid-pair (R7)
                even_code = MAG_W'(45);
                even_sign = 1'b1;
                odd_code  = MAG_W'(27);
                odd_sign  = ~s_os[i];
            end
            @(posedge clk);
            @(negedge clk);
            check_sym({req, " R6 even"}, s_ec[i], s_es[i]);
        end
        @(posedge clk);
        @(negedge clk);
        check_sym({req, " R7 R8 last odd"}, s_oc[n-1], s_os[n-1]);
        @(posedge clk);
        @(negedge clk);
        check_dark("R7 R1 dark after stop");
    endtask

    task automatic test_reset;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_dark("R1 during reset");
        rst_n = 1'b1;
        even_code = MAG_W'(63);
        even_sign = 1'b1;
        odd_code  = MAG_W'(17);
        odd_sign  = 1'b1;
        repeat (4) begin
            @(posedge clk);
            @(negedge clk);
            check_dark("R1 idle with run low");
        end
    endtask

    task automatic test_sweep;
        for (int i = 0; i < 64; i++) begin
            s_ec[i] = i;       s_es[i] = 1'b0;
            s_oc[i] = 63 - i;  s_os[i] = 1'b1;
        end
        run_stream(64, "R2 R3 R5 sweep neg-even");
        for (int i = 0; i < 64; i++) begin
            s_ec[i] = i;       s_es[i] = 1'b1;
            s_oc[i] = 63 - i;  s_os[i] = 1'b0;
        end
        run_stream(64, "R2 R3 R5 sweep pos-even");
    endtask

    task automatic test_zero_code;
        s_ec[0] = 0;  s_es[0] = 1'b1; s_oc[0] = 0;  s_os[0] = 1'b0;
        s_ec[1] = 63; s_es[1] = 1'b1; s_oc[1] = 0;  s_os[1] = 1'b1;
        s_ec[2] = 0;  s_es[2] = 1'b0; s_oc[2] = 1;  s_os[2] = 1'b0;
        run_stream(3, "R4 zero code");
    endtask

    task automatic test_sign_align;
        for (int i = 0; i < 8; i++) begin
            s_ec[i] = 63;    s_es[i] = i[0];
            s_oc[i] = 8 * i; s_os[i] = ~i[0];
        end
        run_stream(8, "R5 sign alignment");
    endtask

    task automatic test_single_pair;
        s_ec[0] = 7; s_es[0] = 1'b1; s_oc[0] = 56; s_os[0] = 1'b0;
        run_stream(1, "R7 single pair");
        s_ec[0] = 9; s_es[0] = 1'b0; s_oc[0] = 54; s_os[0] = 1'b1;
        run_stream(1, "R6 restart");
    endtask

    initial begin
        test_reset();
        test_sweep();
        test_zero_code();
        test_sign_align();
        test_single_pair();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual still running, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule